// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a cache and serves the cache's miss requests. It keeps a short queue of block entries filled ahead of the current access stream. When the cache reports a miss, the block compares the miss address against the oldest queued entry only. On a match it returns that block from the queue on the next cycle, and the freed slot lets the stream run one block further ahead. On any other miss it empties the queue, reads the missed block from memory as a demand read, and starts a new stream at the block that follows it. The cache's own arrays are not part of this block.

The memory side is a block-read channel with a valid/ready request and an in-order response. Demand reads take precedence over prefetch reads. After the queue is emptied, prefetch responses already in flight are still returned by memory. They are thrown away, and the demand read is held back until none remain outstanding.

Control is a six-state machine:
- `ST_IDLE` accepts a miss.
- `ST_DRAIN` waits for outstanding reads to return.
- `ST_DEM_REQ` presents the demand read.
- `ST_DEM_WAIT` waits for its data.
- `ST_HIT_WAIT` waits for a matched head entry whose data has not yet arrived.
- `ST_REPLY` drives the response for one cycle.

Transitions:
- `ST_IDLE` goes to `ST_REPLY` on a head match with data present.
- `ST_IDLE` goes to `ST_HIT_WAIT` on a head match with data still pending.
- `ST_IDLE` goes to `ST_DRAIN` on a mismatch.
- `ST_DRAIN` goes to `ST_DEM_REQ` when nothing is outstanding.
- `ST_DEM_REQ` goes to `ST_DEM_WAIT` when the request is taken.
- `ST_DEM_WAIT` goes to `ST_REPLY` on the demand data.
- `ST_HIT_WAIT` goes to `ST_REPLY` when the head data has arrived.
- `ST_REPLY` always goes back to `ST_IDLE`.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset the block signals `miss_ready`=1, `resp_valid`=0 and `mem_req_valid`=0, and it issues no memory read before the first miss.
- R2: A miss whose address does not equal the head entry's address empties the queue and issues a demand read of that address. The reply carries the memory data, `resp_addr` equal to the miss address, and `resp_from_buf`=0.
- R3: After a demand read of address A, prefetch reads are issued for A+1, A+2, … in increasing order, modulo 2^ADDR_W. The queue never holds more than DEPTH entries.
- R4: A miss that equals the head entry's address, with that entry's data already present, produces `resp_valid` on the cycle right after acceptance. The reply carries that block's data and `resp_from_buf`=1, and no memory read of that address is made.
- R5: A miss that equals a head entry whose data is still pending waits for that data. It then replies with `resp_from_buf`=1 and the correct data.
- R6: A head hit removes the head entry, and the stream continues with the next sequential prefetch address, so that successive sequential misses keep hitting.
- R7: While a demand read is waiting, `mem_req_valid` stays high with the demand address, even when `mem_req_ready` is low. No prefetch read is presented in its place.
- R8: Prefetch responses that return after the queue was emptied are never delivered to the cache. The demand read is not issued until all earlier reads have returned.
- R9: A miss to an address that is queued but is not the head is treated as a mismatch (reply with `resp_from_buf`=0).
- R10: `miss_ready` is low from the acceptance of a miss until its single reply has been given. `resp_valid` lasts one cycle, and there is exactly one reply per accepted miss.
- R11: Prefetch addresses wrap from the all-ones address to zero, and misses on the wrapped addresses still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | Block can accept a miss |
| resp_valid | output | 1 | Reply strobe, one cycle |
| resp_addr | output | ADDR_W | Block address of the reply |
| resp_data | output | DATA_W | Block data of the reply |
| resp_from_buf | output | 1 | Reply came from the prefetch queue |
| mem_req_valid | output | 1 | Memory block-read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Address of the block to read |
| mem_rsp_valid | input | 1 | Memory returns a block (in request order) |
| mem_rsp_data | input | DATA_W | Returned block data |

## Verification
Two events can fall in the same cycle: a prefetch response filling a queue entry, and a miss either popping the head or emptying the queue. Random miss streams provoke this overlap. The streams mix sequential head hits, jumps to random addresses and hits on the second entry, and memory latency changes from one miss to the next, so fills overlap pops and flushes in many phases. Every reply is judged against a model of the expected head address. The data of each reply must match the memory's function of the requested address, which exposes any stale prefetch data that was wrongly passed on. Each memory request is checked against the expected address order and against the count of reads still in flight.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_DEM_REQ,
        ST_DEM_WAIT,
        ST_HIT_WAIT,
        ST_REPLY
    } sbp_state_e;
endpackage

// File: rtl/sbp_store.sv
// Circular queue of prefetched block entries with per-entry valid/pending.
module sbp_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic                          alloc_i,
    input  logic [ADDR_W-1:0]             alloc_addr_i,
    input  logic                          fill_i,
    input  logic [DATA_W-1:0]             fill_data_i,
    input  logic                          pop_i,
    output logic                          head_valid_o,
    output logic                          head_pending_o,
    output logic [ADDR_W-1:0]             head_addr_o,
    output logic [DATA_W-1:0]             head_data_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [PTR_W-1:0]  head_q, tail_q, fptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  ent_valid, ent_pend;
    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic              v_q, p_q;
        logic [ADDR_W-1:0] a_q;
        logic [DATA_W-1:0] d_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                p_q <= 1'b0;
                a_q <= '0;
                d_q <= '0;
            end else if (flush_i) begin
                v_q <= 1'b0;
                p_q <= 1'b0;
            end else begin
                if (alloc_i && tail_q == PTR_W'(i)) begin
                    v_q <= 1'b1;
                    p_q <= 1'b1;
                    a_q <= alloc_addr_i;
                end else if (pop_i && head_q == PTR_W'(i)) begin
                    v_q <= 1'b0;
                end
                if (fill_i && fptr_q == PTR_W'(i)) begin
                    p_q <= 1'b0;
                    d_q <= fill_data_i;
                end
            end
        end
        assign ent_valid[i] = v_q;
        assign ent_pend[i]  = p_q;
        assign ent_addr[i]  = a_q;
        assign ent_data[i]  = d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            fptr_q  <= '0;
            count_q <= '0;
        end else if (flush_i) begin
            head_q  <= '0;
            tail_q  <= '0;
            fptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (alloc_i) tail_q <= bump(tail_q);
            if (pop_i)   head_q <= bump(head_q);
            if (fill_i)  fptr_q <= bump(fptr_q);
            count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(pop_i);
        end
    end

    assign head_valid_o   = ent_valid[head_q];
    assign head_pending_o = ent_pend[head_q];
    assign head_addr_o    = ent_addr[head_q];
    assign head_data_o    = ent_data[head_q];
    assign count_o        = count_q;
    assign full_o         = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/sbp_arb.sv
// Memory channel front: demand over prefetch, count of reads in flight.
module sbp_arb #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dem_req_i,
    input  logic [ADDR_W-1:0]            dem_addr_i,
    input  logic                         pf_req_i,
    input  logic [ADDR_W-1:0]            pf_addr_i,
    input  logic                         mem_req_ready_i,
    input  logic                         mem_rsp_valid_i,
    output logic                         mem_req_valid_o,
    output logic [ADDR_W-1:0]            mem_req_addr_o,
    output logic                         dem_take_o,
    output logic                         pf_take_o,
    output logic [$clog2(DEPTH+2)-1:0]   pend_cnt_o
);
    localparam int OUT_W = $clog2(DEPTH+2);

    logic [OUT_W-1:0] pend_q;

    assign mem_req_valid_o = dem_req_i | pf_req_i;
    assign mem_req_addr_o  = dem_req_i ? dem_addr_i : pf_addr_i;
    assign dem_take_o      = dem_req_i & mem_req_ready_i;
    assign pf_take_o       = pf_req_i & ~dem_req_i & mem_req_ready_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + OUT_W'(dem_take_o | pf_take_o) - OUT_W'(mem_rsp_valid_i);
    end

    assign pend_cnt_o = pend_q;
endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_from_buf,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int OUT_W = $clog2(DEPTH+2);

    sbp_state_e        state, state_nx;
    logic [ADDR_W-1:0] req_q;
    logic [ADDR_W-1:0] pf_next_q;
    logic              stream_on_q;
    logic              head_valid, head_pending, full;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  buf_count;
    logic [OUT_W-1:0]  pend_cnt;
    logic              accept, head_match, flush, pop, fill;
    logic              pf_req, dem_req, dem_take, pf_take;

    assign accept     = (state == ST_IDLE) && miss_valid;
    assign head_match = head_valid && (head_addr == miss_addr);
    assign flush      = accept && !head_match;
    assign pop        = (accept && head_match && !head_pending) ||
                        ((state == ST_HIT_WAIT) && !head_pending);
    assign fill       = mem_rsp_valid && (state != ST_DRAIN) &&
                        (state != ST_DEM_WAIT) && !flush;
    assign dem_req    = (state == ST_DEM_REQ);
    assign pf_req     = stream_on_q && !full && !(state == ST_IDLE && miss_valid) &&
                        (state inside {ST_IDLE, ST_DEM_WAIT, ST_HIT_WAIT, ST_REPLY});
    assign miss_ready = (state == ST_IDLE);
    assign resp_addr  = req_q;

    sbp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush),
        .alloc_i        (pf_take),
        .alloc_addr_i   (pf_next_q),
        .fill_i         (fill),
        .fill_data_i    (mem_rsp_data),
        .pop_i          (pop),
        .head_valid_o   (head_valid),
        .head_pending_o (head_pending),
        .head_addr_o    (head_addr),
        .head_data_o    (head_data),
        .count_o        (buf_count),
        .full_o         (full)
    );

    sbp_arb #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_arb (
        .clk             (clk),
        .rst_n           (rst_n),
        .dem_req_i       (dem_req),
        .dem_addr_i      (req_q),
        .pf_req_i        (pf_req),
        .pf_addr_i       (pf_next_q),
        .mem_req_ready_i (mem_req_ready),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_addr_o  (mem_req_addr),
        .dem_take_o      (dem_take),
        .pf_take_o       (pf_take),
        .pend_cnt_o      (pend_cnt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (miss_valid) begin
                    if (!head_match)      state_nx = ST_DRAIN;
                    else if (head_pending) state_nx = ST_HIT_WAIT;
                    else                   state_nx = ST_REPLY;
                end
            end
            ST_DRAIN:    if (pend_cnt == '0)  state_nx = ST_DEM_REQ;
            ST_DEM_REQ:  if (dem_take)        state_nx = ST_DEM_WAIT;
            ST_DEM_WAIT: if (mem_rsp_valid)   state_nx = ST_REPLY;
            ST_HIT_WAIT: if (!head_pending)   state_nx = ST_REPLY;
            ST_REPLY:                         state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs and stream bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_data     <= '0;
            resp_from_buf <= 1'b0;
            req_q         <= '0;
            pf_next_q     <= '0;
            stream_on_q   <= 1'b0;
        end else begin
            resp_valid <= (state_nx == ST_REPLY);
            if (accept) req_q <= miss_addr;
            if (flush) begin
                stream_on_q <= 1'b1;
                pf_next_q   <= miss_addr + 1'b1;
            end else if (pf_take) begin
                pf_next_q   <= pf_next_q + 1'b1;
            end
            if (pop) begin
                resp_data     <= head_data;
                resp_from_buf <= 1'b1;
            end else if (state == ST_DEM_WAIT && mem_rsp_valid) begin
                resp_data     <= mem_rsp_data;
                resp_from_buf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        miss_valid,
    input logic                        miss_ready,
    input logic [ADDR_W-1:0]           miss_addr,
    input logic                        resp_valid,
    input logic                        resp_from_buf,
    input logic [ADDR_W-1:0]           resp_addr,
    input logic                        mem_req_valid,
    input logic                        mem_req_ready,
    input logic [ADDR_W-1:0]           mem_req_addr,
    input sbp_state_e                  state,
    input logic                        head_valid,
    input logic                        head_pending,
    input logic [ADDR_W-1:0]           head_addr,
    input logic [$clog2(DEPTH+1)-1:0]  buf_count,
    input logic [$clog2(DEPTH+2)-1:0]  pend_cnt
);
    p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && !(head_valid && head_addr == miss_addr)) |=> (buf_count == '0));

    p_depth_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_count <= ($clog2(DEPTH+1))'(DEPTH));

    p_hit_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && head_valid && !head_pending && head_addr == miss_addr)
        |=> (resp_valid && resp_from_buf));

    p_demand_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEM_REQ) |-> (mem_req_valid && mem_req_addr == resp_addr));

    p_demand_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEM_REQ && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEM_REQ) |-> (pend_cnt == '0));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !miss_ready);

    p_single_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
endmodule

bind stream_prefetch_buf sbp_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .miss_addr     (miss_addr),
    .resp_valid    (resp_valid),
    .resp_from_buf (resp_from_buf),
    .resp_addr     (resp_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .state         (state),
    .head_valid    (head_valid),
    .head_pending  (head_pending),
    .head_addr     (head_addr),
    .buf_count     (buf_count),
    .pend_cnt      (pend_cnt)
);

// File: tb/stream_prefetch_buf_bench.sv
`timescale 1ns/1ps
module stream_prefetch_buf_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready, resp_valid, resp_from_buf, mem_req_valid;
    logic [AW-1:0] resp_addr, mem_req_addr;
    logic [DW-1:0] resp_data;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    stream_prefetch_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) u_stream_prefetch_buf (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_data(resp_data),
        .resp_from_buf(resp_from_buf),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // memory model queue
    logic [AW-1:0] q_addr [64];
    int            q_time [64];
    int            q_rd = 0, q_wr = 0, q_n = 0, last_time = 0;
    int            lat_dem = 3, lat_pf = 3;
    int            ready_hold = 0;

    // reference model
    int            cyc = 0;
    bit            stream_on = 0;
    logic [AW-1:0] b_head = '0, pf_exp = '0, dem_addr = '0;
    bit            expect_dem = 0;
    bit            mv_pending = 0;
    logic [AW-1:0] mv_addr = '0;
    bit            busy = 0, got = 0, exp_hit = 0, last_hit = 0;
    int            acc_cyc = 0, last_lat = 0;
    string         cur_tag = "R2";

    function automatic logic [DW-1:0] f_data(input logic [AW-1:0] a);
        return {a ^ 16'hC3A5, a + 16'h3172};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        int t;
        @(negedge clk);
        if (q_n > 0 && q_time[q_rd] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = f_data(q_addr[q_rd]);
            q_rd = (q_rd + 1) % 64;
            q_n--;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        mem_req_ready = (ready_hold == 0);
        if (ready_hold > 0) ready_hold--;
        miss_valid = mv_pending;
        miss_addr  = mv_addr;
        #1;
        if (busy && miss_ready) chk(0, "R10", miss_ready, 0);
        if (resp_valid) begin
            if (!busy) chk(0, "R10", resp_valid, 0);
            else begin
                chk(resp_addr == mv_addr, cur_tag, resp_addr, mv_addr);
                chk(resp_data == f_data(mv_addr), cur_tag, resp_data, f_data(mv_addr));
                chk(resp_from_buf == exp_hit, cur_tag, resp_from_buf, exp_hit);
                last_lat = cyc - acc_cyc;
                last_hit = resp_from_buf;
                busy = 0;
                got  = 1;
            end
        end
        if (mem_req_valid && expect_dem) chk(mem_req_addr == dem_addr, "R7", mem_req_addr, dem_addr);
        if (mem_req_valid && mem_req_ready) begin
            if (expect_dem) begin
                chk(q_n == 0, "R8", q_n, 0);
                expect_dem = 0;
                t = cyc + lat_dem;
            end else begin
                chk(mem_req_addr == pf_exp, "R6", mem_req_addr, pf_exp);
                chk(AW'(pf_exp - b_head) <= AW'(DP - 1), "R3", AW'(pf_exp - b_head), DP - 1);
                pf_exp = pf_exp + 1'b1;
                t = cyc + lat_pf;
            end
            if (q_n > 0 && t <= last_time) t = last_time + 1;
            last_time = t;
            q_addr[q_wr] = mem_req_addr;
            q_time[q_wr] = t;
            q_wr = (q_wr + 1) % 64;
            q_n++;
        end
        if (miss_valid && miss_ready) begin
            mv_pending = 0;
            busy = 1;
            acc_cyc = cyc;
            exp_hit = stream_on && (mv_addr == b_head);
            if (exp_hit) b_head = b_head + 1'b1;
            else begin
                stream_on  = 1;
                expect_dem = 1;
                dem_addr   = mv_addr;
                b_head     = mv_addr + 1'b1;
                pf_exp     = mv_addr + 1'b1;
            end
        end
        cyc++;
    endtask

    task automatic do_miss(input logic [AW-1:0] a, input string tag);
        int w = 0;
        cur_tag = tag;
        mv_addr = a;
        mv_pending = 1;
        got = 0;
        while (!got && w < 3000) begin
            tick();
            w++;
        end
        if (!got) chk(0, "R10", 0, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(miss_ready == 1'b1, "R1", miss_ready, 1);
            chk(resp_valid == 1'b0, "R1", resp_valid, 0);
            chk(mem_req_valid == 1'b0, "R1", mem_req_valid, 0);
        end
        // R2 then R4: demand miss, idle, fast head hit
        do_miss(16'h0100, "R2");
        idle(20);
        do_miss(16'h0101, "R4");
        chk(last_lat == 1 && last_hit, "R4", last_lat, 1);
        // R6: sequential run keeps hitting
        for (int i = 0; i < 8; i++) begin
            do_miss(b_head, "R6");
            chk(last_hit == 1'b1, "R6", last_hit, 1);
        end
        // R9: second entry is not a hit
        idle(10);
        do_miss(b_head + 16'd1, "R9");
        chk(last_hit == 1'b0, "R9", last_hit, 0);
        // R5: pending head
        idle(10);
        lat_dem = 2; lat_pf = 40;
        do_miss(16'h2000, "R2");
        do_miss(16'h2001, "R5");
        chk(last_hit && last_lat > 1, "R5", last_lat, 2);
        // R8: flush with reads in flight, R7: demand held with ready low
        lat_dem = 20; lat_pf = 20;
        do_miss(16'h3000, "R2");
        ready_hold = 3;
        do_miss(16'h7777, "R8");
        chk(last_hit == 1'b0, "R8", last_hit, 0);
        // R11: wrap
        lat_dem = 3; lat_pf = 3;
        idle(30);
        do_miss(16'hFFFE, "R2");
        idle(8);
        do_miss(16'hFFFF, "R11");
        chk(last_hit == 1'b1, "R11", last_hit, 1);
        do_miss(16'h0000, "R11");
        chk(last_hit == 1'b1, "R11", last_hit, 1);
        do_miss(16'h0001, "R11");
        chk(last_hit == 1'b1, "R11", last_hit, 1);
        // random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [AW-1:0] a;
            sel = $urandom_range(99);
            lat_dem = $urandom_range(1, 12);
            lat_pf  = $urandom_range(1, 12);
            if ($urandom_range(9) == 0) ready_hold = $urandom_range(1, 4);
            if (sel < 60)      a = b_head;
            else if (sel < 85) a = AW'($urandom);
            else               a = b_head + 16'd1;
            idle($urandom_range(0, 5));
            do_miss(a, "R2");
        end
        idle(60);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired (R10) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule